// File: doc/BRIEF.md
# Bulk Erase Sequencer for a Two-Wire Programming Port

This block is the host side of a serial programming link. It drives a target's serial clock and serial data pins. A single start pulse, together with a target select, makes it run one complete bulk-erase script with no further help. There are three scripts: one for program memory, one for data memory, and one for the full erase used when code protection is set. Each script sends the fixed series of six-bit commands and sixteen-clock data frames that the target expects. Between frames it keeps the minimum idle gap, and after the erase command it holds the line idle for the erase time.

All timing is counted in system clocks. The clock high and low phases are set by a parameter. The inter-frame gap and the erase wait are derived from the system clock frequency and from nanosecond and microsecond parameters. The block raises `busy` for the length of the script and pulses `done` once when the last frame has finished. Mode-entry voltages, file handling and read-back verification are outside this block.

Top module: `erase_seq`

## Requirements
- R1: After reset, `pgm_clk`, `pgm_dat`, `busy` and `done` are all low.
- R2: A command frame is 6 serial clocks carrying the opcode least significant bit first. The opcodes are: load-config 0x00, load-program 0x02, load-data-memory 0x03, increment-address 0x06, setup-A 0x01, setup-B 0x07, begin-erase 0x08.
- R3: A data frame is 16 serial clocks: a 0 start bit, then the 14-bit word 0x3FFF least significant bit first, then a 0 stop bit. Read as a 16-bit LSb-first value, the frame is 0x7FFE.
- R4: With `target` = 0 (program memory), the frames are load-program, data, setup-A, setup-B, begin-erase, setup-A, setup-B.
- R5: With `target` = 1 (data memory), the frames are the same as in R4, except that the first frame is load-data-memory.
- R6: With `target` = 2 (protected full erase), the frames are load-config, data, seven increment-address commands, setup-A, setup-B, begin-erase, setup-A, setup-B.
- R7: `pgm_dat` changes only while `pgm_clk` is low or at its rising edge. Every clock high phase and every in-frame low phase lasts exactly HALF_CYC system clocks, so data is held at least HALF_CYC cycles before and after each falling edge.
- R8: Between the last falling edge of one frame and the first rising edge of the next, at least HALF_CYC plus the gap count (GAP_NS converted to clocks) elapse. This applies both between a command and its data and between commands.
- R9: After the begin-erase frame, the next rising edge comes no sooner than HALF_CYC plus the erase count (ERASE_US converted to clocks).
- R10: `busy` is high from the cycle after an accepted start until the final frame has completed. `done` is a single-cycle pulse issued with the fall of `busy`. `pgm_clk` is never high while `busy` is low.
- R11: A start while `busy` is high is ignored, and so is a start with `target` = 3. Neither one changes the frame stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a script |
| target | input | 2 | Script select: 0 program, 1 data, 2 protected full, 3 invalid |
| pgm_clk | output | 1 | Serial clock to the target |
| pgm_dat | output | 1 | Serial data to the target |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle pulse at script completion |

## Verification
The assertions take two things for granted. First, `start` is a short pulse. Second, the erase count is larger than the gap count, so the wait timer is never reloaded while it is running. The stimulus drives `start` for one cycle at a time and sets its target on the same cycle. It keeps ERASE_US well above GAP_NS, and it sends the only overlapping start while a script is already running, so that R11 is exercised without breaking the reload assumption. Reset is held for several cycles before the first start, which keeps every history-based property clear of pre-reset values.

// File: rtl/erase_pkg.sv
package erase_pkg;

  typedef enum logic [1:0] {
    TGT_PROG = 2'd0,
    TGT_DATA = 2'd1,
    TGT_FULL = 2'd2,
    TGT_NONE = 2'd3
  } target_e;

  localparam logic [5:0] OP_LOAD_CFG = 6'h00;
  localparam logic [5:0] OP_LOAD_PGM = 6'h02;
  localparam logic [5:0] OP_LOAD_DAT = 6'h03;
  localparam logic [5:0] OP_INC      = 6'h06;
  localparam logic [5:0] OP_SETUP_A  = 6'h01;
  localparam logic [5:0] OP_SETUP_B  = 6'h07;
  localparam logic [5:0] OP_BEGIN    = 6'h08;

  localparam logic [13:0] FILL_WORD = 14'h3FFF;
  localparam int CMD_BITS  = 6;
  localparam int DATA_BITS = 16;

  typedef struct packed {
    logic [5:0] op;
    logic       has_data;
    logic       long_wait;
  } step_t;

  // number of command steps in a script
  function automatic logic [3:0] script_len(target_e t);
    return (t == TGT_FULL) ? 4'd13 : 4'd6;
  endfunction

  // command step idx of the script for target t
  function automatic step_t script_step(target_e t, logic [3:0] idx);
    step_t      s;
    logic [3:0] head;
    logic [3:0] tail;
    s    = '{op: OP_SETUP_B, has_data: 1'b0, long_wait: 1'b0};
    head = (t == TGT_FULL) ? 4'd8 : 4'd1;
    tail = idx - head;
    if (idx == 4'd0) begin
      s.has_data = 1'b1;
      case (t)
        TGT_FULL: s.op = OP_LOAD_CFG;
        TGT_DATA: s.op = OP_LOAD_DAT;
        default:  s.op = OP_LOAD_PGM;
      endcase
    end else if (idx < head) begin
      s.op = OP_INC;
    end else begin
      case (tail)
        4'd0:    s.op = OP_SETUP_A;
        4'd1:    s.op = OP_SETUP_B;
        4'd2:    begin s.op = OP_BEGIN; s.long_wait = 1'b1; end
        4'd3:    s.op = OP_SETUP_A;
        default: s.op = OP_SETUP_B;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int HALF_CYC = 5,
  parameter int FRAME_W  = 16,
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1,
  localparam int BW = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [BW-1:0]      nbits,
  input  logic [FRAME_W-1:0] word,
  output logic               sclk,
  output logic               sdat,
  output logic               fin
);

  localparam logic [CW-1:0] PHASE_LAST = CW'(HALF_CYC - 1);

  logic               active;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      left;
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      left   <= '0;
      sh     <= '0;
      sclk   <= 1'b0;
      sdat   <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          sh     <= word;
          sdat   <= word[0];
          sclk   <= 1'b1;
          cnt    <= PHASE_LAST;
          left   <= nbits - 1'b1;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (sclk) begin
        sclk <= 1'b0;
        cnt  <= PHASE_LAST;
      end else if (left == '0) begin
        active <= 1'b0;
        sdat   <= 1'b0;
        fin    <= 1'b1;
      end else begin
        left <= left - 1'b1;
        sh   <= sh >> 1;
        sdat <= sh[1];
        sclk <= 1'b1;
        cnt  <= PHASE_LAST;
      end
    end
  end

  // R7
  dat_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdat));

  // R7
  dat_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> $stable(sdat));

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  output logic             expire
);

  logic             running;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (load) begin
      running <= 1'b1;
      cnt     <= val - 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign expire = running && (cnt == '0);

  // R8
  reload_free_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !running);

  // R9
  expire_single_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

endmodule

// File: rtl/erase_script.sv
module erase_script
  import erase_pkg::*;
#(
  parameter int GAP_CYC   = 50,
  parameter int ERASE_CYC = 400000,
  parameter int CNT_W     = 19,
  localparam int BW = $clog2(DATA_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       target,
  input  logic             fin,
  input  logic             expire,
  output logic             go,
  output logic [BW-1:0]    nbits,
  output logic [15:0]      word,
  output logic             tload,
  output logic [CNT_W-1:0] tval,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] GAP_V   = CNT_W'(GAP_CYC);
  localparam logic [CNT_W-1:0] ERASE_V = CNT_W'(ERASE_CYC);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_SHIFT, S_PAUSE} st_e;

  st_e        st;
  target_e    tgt_q;
  logic [3:0] idx;
  logic       in_data;
  step_t      cur;
  logic [3:0] last_idx;
  logic       need_data;

  always_comb begin
    cur       = script_step(tgt_q, idx);
    last_idx  = script_len(tgt_q) - 4'd1;
    need_data = cur.has_data && !in_data;
    go        = (st == S_SEND);
    nbits     = in_data ? BW'(DATA_BITS) : BW'(CMD_BITS);
    word      = in_data ? {1'b0, FILL_WORD, 1'b0} : {10'd0, cur.op};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      tgt_q   <= TGT_PROG;
      idx     <= '0;
      in_data <= 1'b0;
      tload   <= 1'b0;
      tval    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done  <= 1'b0;
      tload <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start && target_e'(target) != TGT_NONE) begin
            tgt_q   <= target_e'(target);
            idx     <= '0;
            in_data <= 1'b0;
            busy    <= 1'b1;
            st      <= S_SEND;
          end
        end
        S_SEND: st <= S_SHIFT;
        S_SHIFT: begin
          if (fin) begin
            if (idx == last_idx && !need_data) begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              tload <= 1'b1;
              tval  <= (!need_data && cur.long_wait) ? ERASE_V : GAP_V;
              if (need_data) begin
                in_data <= 1'b1;
              end else begin
                in_data <= 1'b0;
                idx     <= idx + 4'd1;
              end
              st <= S_PAUSE;
            end
          end
        end
        default: begin
          if (expire) st <= S_SEND;
        end
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11
  target_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(tgt_q));

endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int HALF_CYC = 5,
  parameter int GAP_NS   = 1000,
  parameter int ERASE_US = 8000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] target,
  output logic       pgm_clk,
  output logic       pgm_dat,
  output logic       busy,
  output logic       done
);

  localparam int GAP_CYC   = (CLK_HZ / 1_000_000) * GAP_NS / 1000;
  localparam int ERASE_CYC = (CLK_HZ / 1000) * ERASE_US / 1000;
  localparam int WAIT_MAX  = (ERASE_CYC > GAP_CYC) ? ERASE_CYC : GAP_CYC;
  localparam int CNT_W     = $clog2(WAIT_MAX + 1);
  localparam int BW        = $clog2(DATA_BITS + 1);

  logic             go, fin, tload, expire;
  logic [BW-1:0]    nbits;
  logic [15:0]      word;
  logic [CNT_W-1:0] tval;

  erase_script #(
    .GAP_CYC(GAP_CYC), .ERASE_CYC(ERASE_CYC), .CNT_W(CNT_W)
  ) u_script (
    .clk(clk), .rst(rst), .start(start), .target(target),
    .fin(fin), .expire(expire), .go(go), .nbits(nbits), .word(word),
    .tload(tload), .tval(tval), .busy(busy), .done(done)
  );

  frame_shifter #(
    .HALF_CYC(HALF_CYC), .FRAME_W(DATA_BITS)
  ) u_shift (
    .clk(clk), .rst(rst), .go(go), .nbits(nbits), .word(word),
    .sclk(pgm_clk), .sdat(pgm_dat), .fin(fin)
  );

  wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tload), .val(tval), .expire(expire)
  );

  // R10
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pgm_clk);

endmodule

// File: tb/erase_seq_test.sv
module erase_seq_test;

  localparam int CLK_HZ   = 50_000_000;
  localparam int HALF     = 5;
  localparam int GAP_NS   = 1000;
  localparam int ERASE_US = 40;
  localparam int GAP_C    = 50;    // 1000 ns at 50 MHz
  localparam int ERASE_C  = 2000;  // 40 us at 50 MHz
  localparam int MAXF     = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] target = 2'd0;
  logic pgm_clk, pgm_dat, busy, done;

  always #10 clk = ~clk;

  erase_seq #(
    .CLK_HZ(CLK_HZ), .HALF_CYC(HALF), .GAP_NS(GAP_NS), .ERASE_US(ERASE_US)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .target(target),
    .pgm_clk(pgm_clk), .pgm_dat(pgm_dat), .busy(busy), .done(done)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0;
  bit capture = 0, ended = 0;
  bit prev_clk = 0, prev_dat = 0;
  int last_fall, last_rise, last_chg;
  int nfrm, hold_err, ph_err, busy_err, done_seen, done_lag;
  int frm_len[MAXF], frm_val[MAXF], frm_gap[MAXF];
  int n_exp;
  int exp_len[MAXF], exp_val[MAXF], exp_req[MAXF];

  task automatic chk(bit ok, string rq, string what, int act, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (capture) begin
      if (pgm_clk && !prev_clk) begin
        if (nfrm == 0 || cyc - last_fall > 2 * HALF + 1) begin
          if (nfrm > 0 && nfrm < MAXF) frm_gap[nfrm] = cyc - last_fall;
          if (nfrm < MAXF) begin frm_len[nfrm] = 0; frm_val[nfrm] = 0; end
          nfrm++;
        end else if (cyc - last_fall != HALF) ph_err++;
        last_rise = cyc;
      end
      if (!pgm_clk && prev_clk) begin
        if (cyc - last_rise != HALF) ph_err++;
        if (cyc - last_chg < HALF) hold_err++;
        if (nfrm > 0 && nfrm <= MAXF) begin
          frm_val[nfrm-1] = frm_val[nfrm-1] | (int'(pgm_dat) << frm_len[nfrm-1]);
          frm_len[nfrm-1]++;
        end
        last_fall = cyc;
      end
      if (pgm_dat != prev_dat) begin
        if (cyc - last_fall < HALF) hold_err++;
        last_chg = cyc;
      end
      if (pgm_clk && !busy) busy_err++;
      if (done) begin done_seen++; done_lag = cyc - last_fall; end
    end
    prev_clk = pgm_clk;
    prev_dat = pgm_dat;
    if (cyc > 190000 && !ended) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic add_exp(int len, int val, int req);
    exp_len[n_exp] = len; exp_val[n_exp] = val; exp_req[n_exp] = req; n_exp++;
  endtask

  task automatic build_exp(int md);
    n_exp = 0;
    // R2 opcodes, R3 data frame 0x7FFE
    add_exp(6, (md == 2) ? 'h00 : (md == 1) ? 'h03 : 'h02, 0);
    add_exp(16, 'h7FFE, GAP_C);
    if (md == 2) for (int i = 0; i < 7; i++) add_exp(6, 'h06, GAP_C);
    add_exp(6, 'h01, GAP_C);
    add_exp(6, 'h07, GAP_C);
    add_exp(6, 'h08, GAP_C);
    add_exp(6, 'h01, ERASE_C);
    add_exp(6, 'h07, GAP_C);
  endtask

  task automatic run(int md, bit intrude, string rq);
    int t;
    nfrm = 0; hold_err = 0; ph_err = 0; busy_err = 0; done_seen = 0; done_lag = 0;
    last_fall = -1000; last_rise = -1000; last_chg = -1000;
    capture = 1;
    @(posedge clk); #1 start = 1; target = 2'(md);
    @(posedge clk); #1 start = 0;
    @(negedge clk);
    chk(busy == (md != 3), "R10", "busy after start", busy, md != 3);
    t = 0;
    while (done_seen == 0 && t < 20000) begin
      @(posedge clk); #1;
      t++;
      if (intrude && t == 300) begin start = 1; target = 2'd2; end
      if (intrude && t == 301) start = 0;
      if (md == 3 && t == 400) break;
    end
    repeat (300) @(posedge clk);
    @(negedge clk);
    capture = 0;
    if (md == 3) begin
      chk(nfrm == 0, "R11", "frames for invalid target", nfrm, 0);
      chk(busy == 0 && done_seen == 0, "R11", "busy/done for invalid target", busy + done_seen, 0);
      return;
    end
    build_exp(md);
    chk(nfrm == n_exp, rq, "frame count", nfrm, n_exp);
    for (int k = 0; k < n_exp && k < nfrm; k++) begin
      chk(frm_len[k] == exp_len[k], (exp_len[k] == 16) ? "R3" : "R2", "frame length", frm_len[k], exp_len[k]);
      chk(frm_val[k] == exp_val[k], rq, "frame value", frm_val[k], exp_val[k]);
      if (k > 0)
        chk(frm_gap[k] >= HALF + exp_req[k] && frm_gap[k] <= HALF + exp_req[k] + 4,
            (exp_req[k] == ERASE_C) ? "R9" : "R8", "idle gap", frm_gap[k], HALF + exp_req[k]);
    end
    chk(hold_err == 0, "R7", "data hold/setup violations", hold_err, 0);
    chk(ph_err == 0, "R7", "phase length violations", ph_err, 0);
    chk(busy_err == 0, "R10", "clock high while not busy", busy_err, 0);
    chk(done_seen == 1, "R10", "done pulses", done_seen, 1);
    chk(done_lag >= HALF && done_lag <= HALF + 3, "R10", "done after last fall", done_lag, HALF);
    chk(busy == 0, "R10", "busy after done", busy, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk({pgm_clk, pgm_dat, busy, done} == 4'b0, "R1", "outputs in reset",
        {pgm_clk, pgm_dat, busy, done}, 0);
    #1 rst = 0;
    @(negedge clk);
    chk({pgm_clk, pgm_dat, busy, done} == 4'b0, "R1", "outputs after reset",
        {pgm_clk, pgm_dat, busy, done}, 0);
    run(0, 0, "R4");
    run(1, 0, "R5");
    run(2, 0, "R6");
    run(3, 0, "R11");
    run(0, 1, "R11");   // second start while busy must not alter the R4 stream
    run(2, 0, "R6");
    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule